// File: doc/BRIEF.md
# Looping Waveform Playback Controller

This block streams a pre-loaded sample buffer out of a word-addressed memory over and over. It reads one 16-bit word each time the sample-enable input is high. Each word is split into a 14-bit converter code and two marker bits. The top bit is a baseband data bit and the next bit is a frame-sync flag. The lower fourteen bits drive the digital-to-analog converter.

The host first writes a start address and an end address. It then issues a start command. The block steps through the buffer and jumps from the end address back to the start address with no lost sample period. Playback continues until a stop or reload command arrives. While stopped, the converter sits at mid-scale and both markers stay low.

The memory is modelled as a read port with a fixed latency. The block tracks every request in flight, so each output field comes from the same stored word.

Top module: `wfpb_player`

## Requirements
- R1: In every sample the block emits, `dac_code` equals bits 13..0 of a single stored word, `bb_bit` equals bit 15 of that word and `sync_bit` equals bit 14 of that word.
- R2: While running, the block issues exactly one read request (`mem_rd_en` high) in each cycle in which `smp_en` is high. Successive requests use successive addresses, with the address counting up modulo 2^ADDR_W.
- R3: A read of the end address is followed, at the next enabled cycle, by a read of the start address, with no cycle skipped. When the start and end addresses are equal, that single word repeats.
- R4: A start command given while stopped makes the first read request, at the next enabled cycle, use the latched start address. A start command given while running has no effect on the address sequence.
- R5: A stop command ends playback at the next clock edge. No sample from a read already in flight is emitted after that edge.
- R6: A reload command latches `load_first` and `load_last` as the new bounds. A reload given while running also stops playback. The block stays stopped until the next start command.
- R7: Each sample appears on the outputs RD_LAT+1 clock edges after its read request, with `smp_valid` high for exactly that one cycle. Between samples the output fields hold their last value.
- R8: Out of reset and whenever stopped, `dac_code` is 14'h2000, `bb_bit`, `sync_bit` and `smp_valid` are 0, and both bounds are reset to address 0.
- R9: Commands in the same cycle take priority in this order: reload, then stop, then start. A start given together with a stop or a reload is discarded.
- R10: No read request is issued while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample-period enable, one read per high cycle |
| cmd_start | input | 1 | Begin playback from the start address |
| cmd_stop | input | 1 | End playback |
| cmd_load | input | 1 | Latch new bounds and stop |
| load_first | input | ADDR_W | Start address to latch |
| load_last | input | ADDR_W | End address to latch |
| mem_rd_en | output | 1 | Read request to the memory |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_data | input | 16 | Read data, valid RD_LAT cycles after the request |
| dac_code | output | 14 | Converter sample |
| bb_bit | output | 1 | Baseband data marker |
| sync_bit | output | 1 | Sync marker |
| smp_valid | output | 1 | One-cycle strobe per emitted sample |

## Verification
The bench builds the block with ADDR_W = 6 and RD_LAT = 2. The small address space lets random bounds fall in every arrangement: wide buffers, one-word buffers, and an end address below the start address, so the counter has to roll over through all-ones. With a short latency, commands often land while a read is still in the pipeline, which exercises the flush on stop and on reload.

// File: rtl/wfpb_pkg.sv
package wfpb_pkg;

  localparam int WORD_W = 16;
  localparam int SAMP_W = 14;
  localparam logic [SAMP_W-1:0] DAC_MID = SAMP_W'(1 << (SAMP_W - 1));

  // Word layout: marker bits on top, converter code below.
  typedef struct packed {
    logic              bb;
    logic              sync;
    logic [SAMP_W-1:0] samp;
  } wfpb_word_t;

  function automatic wfpb_word_t split_word(input logic [WORD_W-1:0] w);
    return wfpb_word_t'(w);
  endfunction

  function automatic wfpb_word_t idle_word();
    wfpb_word_t r;
    r.bb   = 1'b0;
    r.sync = 1'b0;
    r.samp = DAC_MID;
    return r;
  endfunction

  // Next address in the loop; the caller truncates to its width.
  function automatic logic [31:0] step_addr(input logic [31:0] cur,
                                            input logic [31:0] first,
                                            input logic [31:0] last);
    return (cur == last) ? first : cur + 32'd1;
  endfunction

endpackage

// File: rtl/wfpb_ctrl.sv
module wfpb_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_load,
  input  logic [ADDR_W-1:0] load_first,
  input  logic [ADDR_W-1:0] load_last,
  output logic              run_q,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] last_q,
  output logic              kill,
  output logic              start_acc
);

  assign kill      = cmd_load | cmd_stop;
  assign start_acc = cmd_start & ~run_q & ~kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      if (cmd_load) begin
        first_q <= load_first;
        last_q  <= load_last;
      end
      if (kill)           run_q <= 1'b0;
      else if (start_acc) run_q <= 1'b1;
    end
  end

  a_r6_reload_latches_and_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> (!run_q && first_q == $past(load_first) && last_q == $past(load_last)));

  a_r9_stop_beats_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && cmd_start) |=> !run_q);

  a_r4_start_enters_run: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_stop && !cmd_load) |=> run_q);

endmodule

// File: rtl/wfpb_addr_seq.sv
module wfpb_addr_seq #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_q,
  input  logic              smp_en,
  input  logic              start_acc,
  input  logic [ADDR_W-1:0] first_q,
  input  logic [ADDR_W-1:0] last_q,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wrap_ev
);
  import wfpb_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nx;

  assign rd_en   = run_q & smp_en;
  assign rd_addr = addr_q;
  assign wrap_ev = rd_en & (addr_q == last_q);
  assign addr_nx = ADDR_W'(step_addr(32'(addr_q), 32'(first_q), 32'(last_q)));

  always_ff @(posedge clk) begin
    if (!rst_n)         addr_q <= '0;
    else if (start_acc) addr_q <= first_q;
    else if (rd_en)     addr_q <= addr_nx;
  end

  a_r10_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !rd_en);

  a_r3_wrap_returns_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> addr_q == $past(first_q));

  a_r2_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wrap_ev) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

endmodule

// File: rtl/wfpb_read_pipe.sv
module wfpb_read_pipe #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic kill,
  output logic ret_valid
);

  logic [RD_LAT-1:0] tag_q;

  generate
    if (RD_LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n || kill) tag_q <= '0;
        else                tag_q <= issue;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n || kill) tag_q <= '0;
        else                tag_q <= {tag_q[RD_LAT-2:0], issue};
      end
    end
  endgenerate

  assign ret_valid = tag_q[RD_LAT-1];

  a_r5_flush_on_kill: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !ret_valid);

endmodule

// File: rtl/wfpb_out_stage.sv
module wfpb_out_stage (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_q,
  input  logic        kill,
  input  logic        ret_valid,
  input  logic [15:0] rd_data,
  output logic [13:0] dac_code,
  output logic        bb_bit,
  output logic        sync_bit,
  output logic        smp_valid
);
  import wfpb_pkg::*;

  wfpb_word_t cur_q;
  wfpb_word_t fresh;
  logic       vld_q;

  assign fresh = split_word(rd_data);

  always_ff @(posedge clk) begin
    if (!rst_n || kill || !run_q) begin
      cur_q <= idle_word();
      vld_q <= 1'b0;
    end else if (ret_valid) begin
      cur_q <= fresh;
      vld_q <= 1'b1;
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign dac_code  = cur_q.samp;
  assign bb_bit    = cur_q.bb;
  assign sync_bit  = cur_q.sync;
  assign smp_valid = vld_q;

  a_r8_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (dac_code == DAC_MID && !bb_bit && !sync_bit && !smp_valid));

  a_r7_strobe_only_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> run_q);

  a_r7_hold_between_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !kill && !ret_valid) |=> $stable(dac_code) && $stable(bb_bit) && $stable(sync_bit));

endmodule

// File: rtl/wfpb_player.sv
module wfpb_player #(
  parameter int ADDR_W = 10,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_load,
  input  logic [ADDR_W-1:0] load_first,
  input  logic [ADDR_W-1:0] load_last,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [15:0]       mem_rd_data,
  output logic [13:0]       dac_code,
  output logic              bb_bit,
  output logic              sync_bit,
  output logic              smp_valid
);

  logic              run_q;
  logic [ADDR_W-1:0] first_q;
  logic [ADDR_W-1:0] last_q;
  logic              kill;
  logic              start_acc;
  logic              wrap_ev;
  logic              ret_valid;

  wfpb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_load(cmd_load),
    .load_first(load_first), .load_last(load_last),
    .run_q(run_q), .first_q(first_q), .last_q(last_q),
    .kill(kill), .start_acc(start_acc)
  );

  wfpb_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .run_q(run_q), .smp_en(smp_en), .start_acc(start_acc),
    .first_q(first_q), .last_q(last_q),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .wrap_ev(wrap_ev)
  );

  wfpb_read_pipe #(.RD_LAT(RD_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .issue(mem_rd_en), .kill(kill), .ret_valid(ret_valid)
  );

  wfpb_out_stage u_out (
    .clk(clk), .rst_n(rst_n),
    .run_q(run_q), .kill(kill), .ret_valid(ret_valid), .rd_data(mem_rd_data),
    .dac_code(dac_code), .bb_bit(bb_bit), .sync_bit(sync_bit), .smp_valid(smp_valid)
  );

  a_r3_wrap_seen_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |-> run_q);

endmodule

// File: tb/tb_wfpb_player.sv
`timescale 1ns/100ps
module tb_wfpb_player;

  localparam int AW  = 6;
  localparam int LAT = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_en = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0, cmd_load = 1'b0;
  logic [AW-1:0] load_first = '0, load_last = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [15:0]   mem_rd_data;
  logic [13:0]   dac_code;
  logic          bb_bit, sync_bit, smp_valid;

  always #2 clk = ~clk;

  wfpb_player #(.ADDR_W(AW), .RD_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_load(cmd_load),
    .load_first(load_first), .load_last(load_last),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .dac_code(dac_code), .bb_bit(bb_bit), .sync_bit(sync_bit), .smp_valid(smp_valid)
  );

  // Two-stage memory model
  logic [15:0] mem [DEPTH];
  logic [15:0] rd_d1, rd_d2;
  always_ff @(posedge clk) begin
    rd_d1 <= mem[mem_rd_addr];
    rd_d2 <= rd_d1;
  end
  assign mem_rd_data = rd_d2;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  string ctx = "";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s %s: got %0h expected %0h", req, ctx, what, act, exp);
    end
  endtask

  // Bench reference state
  bit          m_run;
  logic [AW-1:0] m_first, m_last, m_addr;
  bit          p0v, p1v;
  logic [15:0] p0w, p1w;
  logic [13:0] e_dac;
  bit          e_bb, e_sync, e_val;
  bit          m_just_wrapped, m_just_started;

  function automatic logic [13:0] f_code(input logic [15:0] w); return w[13:0]; endfunction
  function automatic bit f_bb(input logic [15:0] w); return w[15]; endfunction
  function automatic bit f_sync(input logic [15:0] w); return w[14]; endfunction
  function automatic logic [AW-1:0] f_next(input logic [AW-1:0] a, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    return (a == hi) ? lo : AW'(a + 1);
  endfunction

  task automatic model_reset();
    m_run = 0; m_first = '0; m_last = '0; m_addr = '0;
    p0v = 0; p1v = 0; p0w = '0; p1w = '0;
    e_dac = 14'h2000; e_bb = 0; e_sync = 0; e_val = 0;
    m_just_wrapped = 0; m_just_started = 0;
  endtask

  task automatic step(input bit st, input bit sp, input bit ld, input bit en,
                      input logic [AW-1:0] f, input logic [AW-1:0] l);
    bit issue, kill, wrap;
    @(negedge clk);
    // registered outputs
    chk(dac_code == e_dac, m_run ? "R1" : "R8", "dac_code", dac_code, e_dac);
    chk(bb_bit == e_bb, m_run ? "R1" : "R8", "bb_bit", bb_bit, e_bb);
    chk(sync_bit == e_sync, m_run ? "R1" : "R8", "sync_bit", sync_bit, e_sync);
    chk(smp_valid == e_val, m_run ? "R7" : "R8", "smp_valid", smp_valid, e_val);
    cmd_start = st; cmd_stop = sp; cmd_load = ld; smp_en = en;
    load_first = f; load_last = l;
    #0.5;
    issue = m_run && en;
    chk(mem_rd_en == issue, m_run ? "R2" : "R10", "mem_rd_en", mem_rd_en, issue);
    if (issue)
      chk(mem_rd_addr == m_addr, m_just_started ? "R4" : (m_just_wrapped ? "R3" : "R2"),
          "mem_rd_addr", mem_rd_addr, m_addr);
    kill = ld || sp;
    // output register
    if (kill || !m_run) begin
      e_dac = 14'h2000; e_bb = 0; e_sync = 0; e_val = 0;
    end else if (p1v) begin
      e_dac = f_code(p1w); e_bb = f_bb(p1w); e_sync = f_sync(p1w); e_val = 1;
    end else e_val = 0;
    p1v = !kill && p0v; p1w = p0w;
    p0v = !kill && issue; p0w = mem[m_addr];
    wrap = 0;
    if (issue) begin
      wrap = (m_addr == m_last);
      m_addr = f_next(m_addr, m_first, m_last);
      m_just_started = 0;
      m_just_wrapped = wrap;
    end
    if (ld) begin m_first = f; m_last = l; m_run = 0; end
    else if (sp) m_run = 0;
    else if (st && !m_run) begin m_run = 1; m_addr = m_first; m_just_started = 1; m_just_wrapped = 0; end
  endtask

  task automatic idle_cycles(input int n, input bit en);
    for (int i = 0; i < n; i++) step(0, 0, 0, en, '0, '0);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'($urandom);
    mem[7] = 16'hC000 | 16'h0123;  // both markers high
    mem[8] = 16'h0000;
    mem[9] = 16'h3FFF;              // full scale, markers low
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset levels, and R10 no reads while enabled but stopped
    ctx = "reset";
    idle_cycles(4, 1);

    // R4 + R3: continuous run over 5..9, wrap without gap
    ctx = "wrap";
    step(0, 0, 1, 1, 6'd5, 6'd9);
    step(1, 0, 0, 1, '0, '0);
    idle_cycles(20, 1);
    // R4: start while running must not restart
    ctx = "restart-ignored";
    step(1, 0, 0, 1, '0, '0);
    idle_cycles(6, 1);
    // R5: stop with reads in flight
    ctx = "stop";
    step(0, 1, 0, 1, '0, '0);
    idle_cycles(5, 1);

    // R3: single-word buffer
    ctx = "one-word";
    step(0, 0, 1, 0, 6'd7, 6'd7);
    step(1, 0, 0, 1, '0, '0);
    idle_cycles(8, 1);

    // R6: reload while running stops and stays stopped
    ctx = "reload-running";
    step(0, 0, 1, 1, 6'd60, 6'd2);
    idle_cycles(6, 1);
    chk(smp_valid == 1'b0 && mem_rd_en == 1'b0, "R6", "still stopped", smp_valid, 0);
    // end below start: rolls over through all-ones
    ctx = "rollover";
    step(1, 0, 0, 1, '0, '0);
    idle_cycles(16, 1);

    // R9: priority among simultaneous commands
    ctx = "stop+start";
    step(1, 1, 0, 1, '0, '0);
    idle_cycles(3, 1);
    ctx = "load+start";
    step(1, 0, 1, 1, 6'd10, 6'd20);
    idle_cycles(3, 1);
    chk(mem_rd_en == 1'b0, "R9", "start discarded", mem_rd_en, 0);

    // R2 + R7: sparse enable
    ctx = "sparse";
    step(1, 0, 0, 0, '0, '0);
    for (int i = 0; i < 40; i++) step(0, 0, 0, (i % 3) == 0, '0, '0);

    // constrained random mix
    ctx = "random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit st, sp, ld, en;
      r  = int'($urandom_range(0, 99));
      ld = (r < 2);
      sp = (r >= 2 && r < 4);
      st = (r >= 4 && r < 10) || ($urandom_range(0, 49) == 0);
      en = ($urandom_range(0, 9) < 6);
      step(st, sp, ld, en, AW'($urandom), AW'($urandom));
    end
    idle_cycles(4, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule